// File: doc/BRIEF.md
# Two-Player Turn-Gated Dice Roller

This block produces die throws for a two-player game in which the players must take turns. Each player has a roll button. A 3-bit counter steps on every clock and is never idle. When the player who holds the turn presses, the counter value at that moment is folded into the range 1 to 6 and captured. The captured value is shown on a seven-LED pip face, and the turn passes to the other player. The roll button of the player who does not hold the turn has no effect.

The scoring logic downstream samples the captured die value on a one-cycle roll strobe and uses the turn flag to see whose throw comes next. A game-over input freezes the block: no press is accepted while it is high, so the face, the die value and the turn flag keep their values. Each button is synchronized and debounced inside the block. A roll is taken only on the debounced rising edge, so holding a button down gives one roll.

Top module: `dice_roller`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, all outputs are zero after that edge: `die_value` 0, `dice_leds` all off, `turn_p1` 0 (player 0 holds the turn), `roll_stb` 0.
- R2: A debounced press from the player who does not hold the turn (player 1 when `turn_p1`=0, player 0 when `turn_p1`=1) is ignored. `turn_p1`, `die_value` and `roll_stb` do not change because of it.
- R3: Each accepted roll inverts `turn_p1` in the same cycle that `roll_stb` is high, so accepted rolls strictly alternate between the players. `turn_p1` changes at no other time.
- R4: A 3-bit raw counter starts at 0 after reset and steps by one on every clock, wrapping from 7 to 0. When a roll is accepted with a raw value r from 0 to 5, `die_value` becomes r+1.
- R5: When a roll is accepted with a raw value of 6 or 7, `die_value` becomes 1 and the raw counter holds 0 in the next cycle.
- R6: `dice_leds` bit i drives LED L(i+1). Die value 1 lights L7 only. Value 2 lights L3 and L4. Value 3 lights L1, L6 and L7. Value 4 lights L1, L3, L4 and L6. Value 5 lights L1, L3, L4, L6 and L7. Value 6 lights L1 to L6 with L7 off. Value 0 lights nothing.
- R7: While `game_over` is high at a clock edge, no roll is accepted at that edge. `roll_stb` stays low, and `die_value`, `dice_leds` and `turn_p1` stay frozen.
- R8: Each button goes through a two-flop synchronizer. Its debounced level changes only after the synchronized level has differed from it for `DEB_LEN` consecutive clocks, so a pulse shorter than that is ignored. A roll is requested only on a debounced rising edge, so a long hold gives one roll.
- R9: An accepted roll raises `roll_stb` for exactly one cycle for that roll. The new `die_value` is present in that same cycle, and `die_value` changes only in cycles where `roll_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_p0 | input | 1 | Raw roll button of player 0, active high |
| btn_p1 | input | 1 | Raw roll button of player 1, active high |
| game_over | input | 1 | Freezes roll acceptance while high |
| die_value | output | 3 | Captured die value, 0 after reset, then 1 to 6 |
| dice_leds | output | 7 | Pip face, bit i drives LED L(i+1) |
| turn_p1 | output | 1 | Turn flag: 0 means player 0 may roll, 1 means player 1 may roll |
| roll_stb | output | 1 | One-cycle strobe on each accepted roll |

## Verification
The bench first gives clean presses from the player who holds the turn. These separate the turn handover from the capture itself. Presses from the wrong player, glitches one clock shorter than the debounce window, and a long hold each check one rejection path on its own: turn gating, filtering, and edge detection. A press while game-over is high checks the freeze apart from the other paths. A sweep then alternates the players with varying press lengths and gaps, so the free-running counter is caught at many different raw values, including 6 and 7. This is what tells the fold-to-1 path apart from the plus-one path and covers every LED face.

// File: rtl/dice_pkg.sv
// Package: shared widths, types and the raw-to-die fold for the dice roller.
// Assumes a six-sided die fed from a 3-bit raw counter.
package dice_pkg;
    localparam int DIE_W     = 3;
    localparam int LED_N     = 7;
    localparam int PLAYERS   = 2;
    localparam int FACE_MAX  = 6;

    typedef logic [DIE_W-1:0] die_t;
    typedef logic [LED_N-1:0] face_t;

    // Maps a raw count to a die value: 0..5 -> 1..6, anything above -> 1.
    function automatic die_t fold_raw(input die_t raw);
        if (raw < die_t'(FACE_MAX))
            return raw + die_t'(1);
        return die_t'(1);
    endfunction
endpackage

// File: rtl/dice_btn_filter.sv
// Module: dice_btn_filter
// Synchronizes one raw button, filters bounce and emits a one-cycle pulse
// on each debounced rising edge. Assumes the button is asynchronous to clk.
// The debounced level follows the synchronized input only after DEB_LEN
// consecutive clocks of disagreement.
module dice_btn_filter #(
    parameter int DEB_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press_pls
);
    localparam int DEB_W = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
    localparam logic [DEB_W-1:0] RUN_LAST = DEB_W'(DEB_LEN - 1);

    logic             sync_a;
    logic             sync_b;
    logic             level_q;
    logic             level_d1;
    logic [DEB_W-1:0] run_q;

    // Two-flop synchronizer for the raw button.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= btn_raw;
            sync_b <= sync_a;
        end
    end

    // Debounce: count disagreeing clocks, adopt the new level at DEB_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (sync_b == level_q) begin
            run_q   <= '0;
        end else if (run_q == RUN_LAST) begin
            level_q <= sync_b;
            run_q   <= '0;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    // Delayed copy of the debounced level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d1 <= 1'b0;
        else        level_d1 <= level_q;
    end

    assign press_pls = level_q & ~level_d1;
endmodule

// File: rtl/dice_rng.sv
// Module: dice_rng
// Free-running 3-bit raw counter. It steps every clock and wraps 7 -> 0.
// When a roll takes a raw value of 6 or 7, it restarts at 0. Presents the
// folded die value for capture. Assumes 'take' is high for one cycle per roll.
module dice_rng
    import dice_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output die_t die_next
);
    die_t raw_q;

    // Raw counter: restart on a folded capture, otherwise step and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else if (take && (raw_q >= die_t'(FACE_MAX)))
            raw_q <= '0;
        else
            raw_q <= raw_q + 1'b1;
    end

    assign die_next = fold_raw(raw_q);
endmodule

// File: rtl/dice_face_enc.sv
// Module: dice_face_enc
// Converts a die value into the seven-LED pip face. Bit i drives L(i+1).
// Values outside 1..6 turn every LED off.
module dice_face_enc
    import dice_pkg::*;
(
    input  die_t  die,
    output face_t leds
);
    // Pip lookup per die value.
    always_comb begin
        unique case (die)
            3'd1:    leds = 7'b100_0000;
            3'd2:    leds = 7'b000_1100;
            3'd3:    leds = 7'b110_0001;
            3'd4:    leds = 7'b010_1101;
            3'd5:    leds = 7'b110_1101;
            3'd6:    leds = 7'b011_1111;
            default: leds = 7'b000_0000;
        endcase
    end
endmodule

// File: rtl/dice_roller.sv
// Module: dice_roller (top)
// Two-player, turn-gated dice roller. A debounced press from the player
// who holds the turn captures a folded raw count, raises a one-cycle
// strobe and hands the turn over. game_over blocks acceptance.
// Assumes synchronous active-low reset and asynchronous raw buttons.
module dice_roller
    import dice_pkg::*;
#(
    parameter int DEB_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_p0,
    input  logic       btn_p1,
    input  logic       game_over,
    output logic [2:0] die_value,
    output logic [6:0] dice_leds,
    output logic       turn_p1,
    output logic       roll_stb
);
    logic [PLAYERS-1:0] btn_vec;
    logic [PLAYERS-1:0] press_pls;
    logic               accept;
    die_t               die_next;
    die_t               die_q;
    logic               turn_q;
    logic               stb_q;

    assign btn_vec = {btn_p1, btn_p0};

    // One synchronizer/debounce/edge filter per player.
    for (genvar p = 0; p < PLAYERS; p++) begin : g_btn
        dice_btn_filter #(.DEB_LEN(DEB_LEN)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .btn_raw   (btn_vec[p]),
            .press_pls (press_pls[p])
        );
    end

    assign accept = ~game_over & press_pls[turn_q];

    dice_rng u_rng (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (accept),
        .die_next (die_next)
    );

    // Capture the die, pass the turn and pulse the strobe on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            die_q  <= '0;
            turn_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= accept;
            if (accept) begin
                die_q  <= die_next;
                turn_q <= ~turn_q;
            end
        end
    end

    dice_face_enc u_face (
        .die  (die_q),
        .leds (dice_leds)
    );

    assign die_value = die_q;
    assign turn_p1   = turn_q;
    assign roll_stb  = stb_q;
endmodule

// File: rtl/dice_roller_chk.sv
// Module: dice_roller_chk
// Property checker for dice_roller. It is bound to the top and watches the
// ports and the per-player press pulses.
module dice_roller_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       game_over,
    input logic [1:0] press_pls,
    input logic [2:0] die_value,
    input logic [6:0] dice_leds,
    input logic       turn_p1,
    input logic       roll_stb
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (die_value == 3'd0 && dice_leds == 7'd0 && !turn_p1 && !roll_stb)); // R1

    AST_ONLY_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        !press_pls[turn_p1] |=> !roll_stb); // R2

    AST_TURN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        roll_stb |-> (turn_p1 != $past(turn_p1))); // R3

    AST_TURN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_stb |-> $stable(turn_p1)); // R3

    AST_DIE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        roll_stb |-> (die_value >= 3'd1 && die_value <= 3'd6)); // R4

    AST_PIP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dice_leds) == int'(die_value)); // R6

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        game_over |=> !roll_stb); // R7

    AST_DIE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_stb |-> $stable(die_value)); // R9
endmodule

bind dice_roller dice_roller_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .game_over (game_over),
    .press_pls (press_pls),
    .die_value (die_value),
    .dice_leds (dice_leds),
    .turn_p1   (turn_p1),
    .roll_stb  (roll_stb)
);

// File: tb/test_dice_roller.sv
// Bench for dice_roller. A behavioural reference model steps on each rising
// edge and is compared with the ports on each falling edge.
module test_dice_roller;
    localparam int DEB_LEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_p0 = 1'b0;
    logic       btn_p1 = 1'b0;
    logic       game_over = 1'b0;
    logic [2:0] die_value;
    logic [6:0] dice_leds;
    logic       turn_p1;
    logic       roll_stb;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string phase = "init";

    // reference model state
    int m_s1[2], m_s2[2], m_lvl[2], m_prev[2], m_run[2];
    int m_raw, m_die, m_turn, m_stb;
    int raw_seen[8];
    int dut_rolls = 0;

    always #5 clk = ~clk;

    dice_roller #(.DEB_LEN(DEB_LEN)) i_dice_roller (
        .clk(clk), .rst_n(rst_n), .btn_p0(btn_p0), .btn_p1(btn_p1),
        .game_over(game_over), .die_value(die_value), .dice_leds(dice_leds),
        .turn_p1(turn_p1), .roll_stb(roll_stb)
    );

    function automatic int exp_face(int d);
        int f = 0;
        if (d >= 3 && d <= 6)            f |= (1 << 0) | (1 << 5); // L1, L6
        if (d == 6)                      f |= (1 << 1) | (1 << 4); // L2, L5
        if (d == 2 || d == 4 || d == 5 || d == 6) f |= (1 << 2) | (1 << 3); // L3, L4
        if (d == 1 || d == 3 || d == 5)  f |= (1 << 6);            // L7
        return f;
    endfunction

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", what, phase, act, exp, $time);
        end
    endtask

    // Reference model, stepped on every rising edge.
    always @(posedge clk) begin
        int pl[2];
        int btn[2];
        btn[0] = int'(btn_p0);
        btn[1] = int'(btn_p1);
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_s1[p] = 0; m_s2[p] = 0; m_lvl[p] = 0; m_prev[p] = 0; m_run[p] = 0;
            end
            m_raw = 0; m_die = 0; m_turn = 0; m_stb = 0;
        end else begin
            for (int p = 0; p < 2; p++) pl[p] = (m_lvl[p] == 1 && m_prev[p] == 0) ? 1 : 0;
            if (!game_over && pl[m_turn] == 1) begin
                raw_seen[m_raw]++;
                m_die  = (m_raw <= 5) ? m_raw + 1 : 1;
                m_stb  = 1;
                m_turn = 1 - m_turn;
                m_raw  = (m_raw >= 6) ? 0 : m_raw + 1;
            end else begin
                m_stb = 0;
                m_raw = (m_raw + 1) % 8;
            end
            for (int p = 0; p < 2; p++) begin
                m_prev[p] = m_lvl[p];
                if (m_s2[p] == m_lvl[p]) m_run[p] = 0;
                else if (m_run[p] == DEB_LEN - 1) begin m_lvl[p] = m_s2[p]; m_run[p] = 0; end
                else m_run[p]++;
                m_s2[p] = m_s1[p];
                m_s1[p] = btn[p];
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R4 R5 die_value", int'(die_value), m_die);
            chk("R6 dice_leds", int'(dice_leds), exp_face(m_die));
            chk("R2 R3 turn_p1", int'(turn_p1), m_turn);
            chk("R8 R9 roll_stb", int'(roll_stb), m_stb);
            if (roll_stb) dut_rolls++;
        end
    end

    task automatic press(int who, int hold, int gap);
        @(negedge clk);
        if (who == 0) btn_p0 = 1'b1; else btn_p1 = 1'b1;
        repeat (hold) @(negedge clk);
        btn_p0 = 1'b0;
        btn_p1 = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        int rolls_before;
        phase = "R1 reset";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 die_value", int'(die_value), 0);
        chk("R1 dice_leds", int'(dice_leds), 0);
        chk("R1 turn_p1", int'(turn_p1), 0);
        chk("R1 roll_stb", int'(roll_stb), 0);
        rst_n = 1'b1;
        cmp_en = 1;

        phase = "R3 player0 roll";
        press(0, DEB_LEN + 2, 10);
        chk("R3 turn after player0", int'(turn_p1), 1);

        phase = "R2 wrong player";
        rolls_before = dut_rolls;
        press(0, DEB_LEN + 2, 10);
        chk("R2 ignored press strobes", dut_rolls - rolls_before, 0);
        chk("R2 turn unchanged", int'(turn_p1), 1);

        phase = "R3 player1 roll";
        press(1, DEB_LEN + 2, 10);
        chk("R3 turn after player1", int'(turn_p1), 0);

        phase = "R8 glitch";
        rolls_before = dut_rolls;
        press(0, DEB_LEN - 1, 10);
        chk("R8 glitch strobes", dut_rolls - rolls_before, 0);

        phase = "R8 long hold";
        rolls_before = dut_rolls;
        press(0, 40, 10);
        chk("R8 single roll on hold", dut_rolls - rolls_before, 1);

        phase = "R7 frozen";
        game_over = 1'b1;
        rolls_before = dut_rolls;
        press(1, DEB_LEN + 2, 10);
        chk("R7 frozen strobes", dut_rolls - rolls_before, 0);
        chk("R7 turn frozen", int'(turn_p1), 1);
        game_over = 1'b0;

        phase = "R4 R5 R6 sweep";
        for (int k = 0; k < 64; k++)
            press((k + 1) % 2, DEB_LEN + (k % 3), 2 + (k * 5) % 13);
        repeat (10) @(negedge clk);

        $display("raw values captured 0..7: %0d %0d %0d %0d %0d %0d %0d %0d",
                 raw_seen[0], raw_seen[1], raw_seen[2], raw_seen[3],
                 raw_seen[4], raw_seen[5], raw_seen[6], raw_seen[7]);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (%s) actual=timeout expected=completion", phase);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule